// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block controls a 32-pin general-purpose I/O port through a simple register interface made of a select strobe, a write flag, an address and a 32-bit data word. Software turns pins into outputs or inputs by writing ones to two separate direction registers. One register turns on the output drive and the other turns it off. Pins whose bit is zero keep their direction. Because of this, one pin can be changed without first reading the direction word back.

Output levels are held in two half-word latches. Each write to a latch carries a 16-bit enable field in its upper half and 16 new values in its lower half. Only the enabled bits change, so a single pin can be set or cleared in one access. The latch keeps its value whatever the pin's direction is, so a level can be preloaded before the driver is turned on. Pin levels pass through a two-stage synchronizer before software can read them. The output enable and output value of every pin leave the block as ports, and a pad ring outside the block uses them.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), every output latch bit is 0 (`pin_out` all 0), and `bus_rdata` is 0.
- R2: A write to offset 0x00 sets `pin_oe[i]` for every i whose data bit is 1. Every other `pin_oe` bit keeps its value. The change is visible on the first clock edge after the strobe.
- R3: A write to offset 0x04 clears `pin_oe[i]` for every i whose data bit is 1. Every other `pin_oe` bit keeps its value.
- R4: A write to offset 0x08 controls pins 0-15. For each j in 0..15 where data bit 16+j is 1, `pin_out[j]` takes data bit j. Where data bit 16+j is 0, `pin_out[j]` is unchanged. Pins 16-31 are untouched.
- R5: A write to offset 0x0C does the same for pins 16-31. Data bit 16+j enables pin 16+j, data bit j is its value, and pins 0-15 are untouched.
- R6: The output latch is independent of direction. Writes to an input pin's latch take effect, and changing direction never alters `pin_out`.
- R7: A read of offset 0x10 returns the pin levels as sampled through two flip-flop stages. A change on `pin_in` just before clock edge k is returned by a read strobed after edge k+1, but not by a read strobed between edges k and k+1.
- R8: A read of offset 0x04 returns the direction word (1 = output). Reads of 0x08 and 0x0C return the latch bits of pins 0-15 and 16-31, respectively, in bits 15:0, with bits 31:16 zero. Read data appears on `bus_rdata` at the first clock edge after the strobe and holds until the next read.
- R9: Reads of offset 0x00 and of any unmapped offset (for example 0x14 or 0x02) return 0. Writes to unmapped offsets change neither `pin_oe` nor `pin_out`.
- R10: A read access never changes `pin_oe` or `pin_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |
| pin_out | output | 32 | Per-pin output latch value |

## Verification
Every register result is due one clock edge after its strobe. For writes, `pin_oe` and `pin_out` have moved by then. For reads, `bus_rdata` holds the selected word by then. The bench drives each access on a falling edge and pushes the expected read word into a queue. A monitor pops that word on the next falling edge, so every comparison falls exactly one edge after the access. Port levels after a write are sampled on the same falling edge. The synchronizer is checked by changing `pin_in` on a falling edge and then issuing two back-to-back reads. The first read, captured two edges later, must still return the old level, and the second read must return the new one.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    // Number of pins in the port; the output latch is split into two halves.
    parameter int PINS = 32;
    parameter int HALF = PINS / 2;

    // Register offsets (software decodes these).
    parameter int OFS_DIR_SET = 'h00;
    parameter int OFS_DIR_CLR = 'h04;
    parameter int OFS_OUT_LO  = 'h08;
    parameter int OFS_OUT_HI  = 'h0C;
    parameter int OFS_PIN_IN  = 'h10;

    typedef struct packed {
        logic [PINS-1:0] dir;
        logic [PINS-1:0] rdata;
    } port_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2*HW-1:0] wdata,
    output logic [HW-1:0] lat_q
);
    logic [HW-1:0] lat_d;
    logic [HW-1:0] mask;
    logic [HW-1:0] val;

    assign mask = wdata[2*HW-1:HW];
    assign val  = wdata[HW-1:0];

    always_comb begin
        lat_d = lat_q;
        if (wr_en) begin
            lat_d = (lat_q & ~mask) | (val & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_oe,
    output logic [PINS-1:0]   pin_out
);
    localparam int NBANK = PINS / HALF;

    port_state_t st_d, st_q;
    logic [PINS-1:0]  pins_sync;
    logic [PINS-1:0]  lat;
    logic [NBANK-1:0] bank_we;
    logic hit_set, hit_clr, hit_lo, hit_hi, hit_in;
    logic do_wr, do_rd;

    assign hit_set = (bus_addr == ADDR_W'(OFS_DIR_SET));
    assign hit_clr = (bus_addr == ADDR_W'(OFS_DIR_CLR));
    assign hit_lo  = (bus_addr == ADDR_W'(OFS_OUT_LO));
    assign hit_hi  = (bus_addr == ADDR_W'(OFS_OUT_HI));
    assign hit_in  = (bus_addr == ADDR_W'(OFS_PIN_IN));
    assign do_wr   = bus_sel &  bus_wr;
    assign do_rd   = bus_sel & ~bus_wr;

    assign bank_we[0] = do_wr & hit_lo;
    assign bank_we[1] = do_wr & hit_hi;

    gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_out_bank #(.HW(HALF)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bank_we[b]),
            .wdata (bus_wdata),
            .lat_q (lat[b*HALF +: HALF])
        );
    end

    always_comb begin
        st_d = st_q;
        if (do_wr) begin
            if (hit_set) st_d.dir = st_q.dir | bus_wdata;
            if (hit_clr) st_d.dir = st_q.dir & ~bus_wdata;
        end
        if (do_rd) begin
            st_d.rdata = '0;
            if (hit_clr) st_d.rdata = st_q.dir;
            if (hit_lo)  st_d.rdata = {{(PINS-HALF){1'b0}}, lat[HALF-1:0]};
            if (hit_hi)  st_d.rdata = {{(PINS-HALF){1'b0}}, lat[PINS-1:HALF]};
            if (hit_in)  st_d.rdata = pins_sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign pin_oe    = st_q.dir;
    assign pin_out   = lat;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
    import gpio_mask_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pin_oe,
    input logic [PINS-1:0]   pin_out
);
    logic wr_set, wr_clr, wr_lo, wr_hi, rd_any, unmapped;

    assign wr_set = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DIR_SET);
    assign wr_clr = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_DIR_CLR);
    assign wr_lo  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_OUT_LO);
    assign wr_hi  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_OUT_HI);
    assign rd_any = bus_sel && !bus_wr;
    assign unmapped = bus_addr != ADDR_W'(OFS_DIR_SET) && bus_addr != ADDR_W'(OFS_DIR_CLR)
                   && bus_addr != ADDR_W'(OFS_OUT_LO) && bus_addr != ADDR_W'(OFS_OUT_HI)
                   && bus_addr != ADDR_W'(OFS_PIN_IN);

    assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))
                && ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata))));

    assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_oe & $past(bus_wdata)) == '0)
                && ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata))));

    assert_lo_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (((pin_out[HALF-1:0] ^ $past(pin_out[HALF-1:0])) & ~$past(bus_wdata[PINS-1:HALF])) == '0)
               && $stable(pin_out[PINS-1:HALF]));

    assert_hi_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (((pin_out[PINS-1:HALF] ^ $past(pin_out[PINS-1:HALF])) & ~$past(bus_wdata[PINS-1:HALF])) == '0)
               && $stable(pin_out[HALF-1:0]));

    assert_dir_keeps_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> $stable(pin_out));

    assert_unmapped_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && unmapped) |=> (bus_rdata == '0));

    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && unmapped) |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/gpio_mask_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] m_oe = '0;
    logic [31:0] m_out = '0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        was_read = 1'b0;

    always #5 clk = ~clk;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: a read strobed before a rising edge is compared at the following falling edge.
    always @(posedge clk) was_read <= bus_sel && !bus_wr;

    always @(negedge clk) begin
        if (was_read) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R8: unexpected read result %h expected none", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        exp_q.push_back(exp);
        tag_q.push_back(req);
    endtask

    task automatic do_idle();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        case (a)
            8'h00: m_oe = m_oe | d;
            8'h04: m_oe = m_oe & ~d;
            8'h08: m_out[15:0]  = (m_out[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
            8'h0C: m_out[31:16] = (m_out[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
            default: ;
        endcase
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        check({req, " oe"}, pin_oe, m_oe);
        check({req, " out"}, pin_out, m_out);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state on ports
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;

        do_read(8'h04, 32'h0, "R1");
        // R6: preload while pins are inputs
        do_write(8'h08, 32'hFFFF_A5A5, "R6");
        // R2: set outputs, accumulates
        do_write(8'h00, 32'h0000_00FF, "R2");
        do_write(8'h00, 32'h0F00_0000, "R2");
        // R3: clear some
        do_write(8'h04, 32'h0000_000F, "R3");
        // R4: change only bit 0 low; unmasked ones ignored
        do_write(8'h08, 32'h0001_FFFE, "R4");
        // R5: high half masked write
        do_write(8'h0C, 32'hF000_5000, "R5");
        do_write(8'h0C, 32'h0003_FFFF, "R5");
        // R8: readback
        do_read(8'h08, {16'h0, m_out[15:0]}, "R8");
        do_read(8'h0C, {16'h0, m_out[31:16]}, "R8");
        do_read(8'h04, m_oe, "R8");
        // R9: write-only and unmapped reads return zero, unmapped writes ignored
        do_read(8'h00, 32'h0, "R9");
        do_read(8'h14, 32'h0, "R9");
        do_write(8'h14, 32'hFFFF_FFFF, "R9");
        do_write(8'h02, 32'hFFFF_FFFF, "R9");
        // R6: direction change leaves latch
        do_write(8'h04, 32'hFFFF_FFFF, "R6");
        do_write(8'h00, 32'h0000_FFFF, "R6");
        // R7: synchronizer latency
        @(negedge clk);
        bus_sel = 1'b0;
        pin_in = 32'h1234_5678;
        do_read(8'h10, 32'h0, "R7 old");
        do_read(8'h10, 32'h1234_5678, "R7 new");
        do_idle();
        @(negedge clk);
        pin_in = 32'hCAFE_0001;
        do_idle(); do_idle();
        do_read(8'h10, 32'hCAFE_0001, "R7");
        // R10: reads do not touch ports
        for (int i = 0; i < 4; i++) do_read(8'h08, {16'h0, m_out[15:0]}, "R10");
        do_idle();
        do_idle();
        check("R10 oe", pin_oe, m_oe);
        check("R10 out", pin_out, m_out);
        check("R8 queue drained", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule